// File: doc/BRIEF.md
# Link Debug and DC Connectivity Test Registers

This block is a small addressed register file placed beside a serial data/strobe bus interface. Its job is debug visibility and a static connectivity test. It holds a scratch register in which every bit can be written and read, so stuck bits on the register path show up. It records the identifier and priority of the node that last won the bus. It also lets software sample the receive data and strobe pins and the two clock-select straps through a synchronizer, and it reports the levels currently driven on the transmit pins and their output enables.

In normal operation the transmit data, transmit strobe and both output enables pass through one register stage from the link logic. The test mode needs two things at once: the hardware test pin must be high and the software enable bit must be set. While both hold, the transmit pins carry static levels taken from two control bits, and both output enables are forced on. Software can then read back the driven levels and the received levels, and compare them, to prove the path from the block through the transceiver to the bus and back. The bus does not work while the test runs. Dropping either the test pin or the enable bit returns the block to normal operation.

Register map: address 0 is scratch, 1 is control, 2 is last winner identifier, 3 is receive pin capture, 6 is last winner priority, 7 is transmit status. Every other address reads zero.

Top module: `link_dbg_regs`

## Requirements
- R1: After synchronous reset, scratch and control read 0, the winner identifier reads 0x3F, the winner priority reads 0x0F, and all four transmit outputs are 0.
- R2: Address 0 is a scratch register: all 8 bits written are read back unchanged. Bits 7:6 carry no function in the block.
- R3: Address 1 is control: bit 0 is the test enable, bit 1 is the data level and bit 2 is the strobe level. All three read back as written, and bits 7:3 read 0.
- R4: A cycle with winner_valid high loads winner_id into address 2 (bits 5:0) and winner_pri into address 6 (bits 3:0). Both are visible from the next cycle.
- R5: A cycle with bus_reset high sets the winner identifier to all ones and the winner priority to all ones. If winner_valid is high in the same cycle, bus_reset wins.
- R6: Address 3 reads the receive pins after a two-flop synchronizer: bit 0 is receive data, bit 1 is receive strobe, and bits 3:2 are clk_sel. A pin level present before a clock edge is seen by a read issued two or more edges later.
- R7: When test_pin was high and the enable bit was 1 at a clock edge, from that edge tx_data_out equals the data level bit, tx_strb_out equals the strobe level bit, and data_oe and strb_oe are both 1.
- R8: At any other edge, tx_data_out, tx_strb_out, data_oe and strb_oe take the values of tx_data_in, tx_strb_in, data_oe_in and strb_oe_in sampled at that edge.
- R9: Address 7 reads the registered transmit outputs: bit 0 is tx_data_out, bit 1 is tx_strb_out, bit 2 is data_oe and bit 3 is strb_oe. Bits 7:4 read 0.
- R10: Writes to addresses 2, 3, 6, 7 and to all unused addresses change no state. Reads of unused addresses return 0.
- R11: rd_data updates at the edge that samples rd_en high and holds otherwise. A read at the same edge as a write to the same address returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| winner_valid | input | 1 | Pulse: a node has won the bus |
| winner_id | input | 6 | Identifier of the winning node |
| winner_pri | input | 4 | Priority of the winning packet |
| bus_reset | input | 1 | Pulse: bus reset occurred |
| test_pin | input | 1 | Hardware enable for the DC test mode |
| rx_data_pin | input | 1 | Receive data pin (asynchronous) |
| rx_strb_pin | input | 1 | Receive strobe pin (asynchronous) |
| clk_sel | input | 2 | Clock select strap pins |
| tx_data_in | input | 1 | Transmit data from link logic |
| tx_strb_in | input | 1 | Transmit strobe from link logic |
| data_oe_in | input | 1 | Data output enable from link logic |
| strb_oe_in | input | 1 | Strobe output enable from link logic |
| tx_data_out | output | 1 | Transmit data pin |
| tx_strb_out | output | 1 | Transmit strobe pin |
| data_oe | output | 1 | Data output enable pin |
| strb_oe | output | 1 | Strobe output enable pin |

## Verification
Two pairs of functions can land on the same edge. A bus reset can coincide with a new winner report. A write that changes the control register can coincide with a toggle of test_pin and with new normal transmit values, which decides whether the override or the pass-through path feeds the output registers. A random phase drives writes, reads, winner reports, bus resets, test_pin and the transmit inputs at the same time, and judges each edge against a bench model that uses the register values from before the edge. Directed cases force the bus-reset-with-winner collision and run a loopback, in which the driven transmit levels return on the receive pins and are compared at addresses 3 and 7.

// File: rtl/link_dbg_pkg.sv
package link_dbg_pkg;

  // register addresses (decoded against an ADDR_W-bit address)
  localparam int unsigned ADR_SCRATCH = 0;
  localparam int unsigned ADR_CTRL    = 1;
  localparam int unsigned ADR_WIN_ID  = 2;
  localparam int unsigned ADR_PINS    = 3;
  localparam int unsigned ADR_WIN_PRI = 6;
  localparam int unsigned ADR_TX_STAT = 7;

  // control register bit positions
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_DLVL_BIT = 1;
  localparam int unsigned CTRL_SLVL_BIT = 2;
  localparam int unsigned CTRL_W        = 3;

  // width of the pin capture and transmit status fields
  localparam int unsigned PINS_W = 4;
  localparam int unsigned TXST_W = 4;

  typedef struct packed {
    logic slvl;
    logic dlvl;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic strb_oe;
    logic data_oe;
    logic strb;
    logic data;
  } tx_pins_t;

  function automatic logic is_mapped(input int unsigned a);
    return (a == ADR_SCRATCH) || (a == ADR_CTRL) || (a == ADR_WIN_ID) ||
           (a == ADR_PINS) || (a == ADR_WIN_PRI) || (a == ADR_TX_STAT);
  endfunction

endpackage

// File: rtl/link_dbg_sync.sv
module link_dbg_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/link_dbg_override.sv
module link_dbg_override
  import link_dbg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hw_test,
  input  ctrl_t    ctrl,
  input  tx_pins_t normal_in,
  output tx_pins_t pins_q,
  output logic     force_on
);

  tx_pins_t pins_d;

  assign force_on = hw_test & ctrl.en;

  always_comb begin
    if (force_on) begin
      pins_d.data    = ctrl.dlvl;
      pins_d.strb    = ctrl.slvl;
      pins_d.data_oe = 1'b1;
      pins_d.strb_oe = 1'b1;
    end else begin
      pins_d = normal_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pins_q <= '0;
    else     pins_q <= pins_d;
  end

endmodule

// File: rtl/link_dbg_regfile.sv
module link_dbg_regfile
  import link_dbg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned PRI_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              winner_valid,
  input  logic [ID_W-1:0]   winner_id,
  input  logic [PRI_W-1:0]  winner_pri,
  input  logic              bus_reset,
  input  logic [PINS_W-1:0] pins_cap,
  input  tx_pins_t          tx_stat,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] scratch_q,
  output logic [ID_W-1:0]   win_id_q,
  output logic [PRI_W-1:0]  win_pri_q
);

  localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(ADR_SCRATCH);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_WID = ADDR_W'(ADR_WIN_ID);
  localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(ADR_PINS);
  localparam logic [ADDR_W-1:0] A_WPR = ADDR_W'(ADR_WIN_PRI);
  localparam logic [ADDR_W-1:0] A_TXS = ADDR_W'(ADR_TX_STAT);

  logic              wr_scr;
  logic              wr_ctl;
  logic [DATA_W-1:0] rd_mux;

  assign wr_scr = wr_en && (addr == A_SCR);
  assign wr_ctl = wr_en && (addr == A_CTL);

  // scratch: every bit writable
  always_ff @(posedge clk) begin
    if (rst)         scratch_q <= '0;
    else if (wr_scr) scratch_q <= wr_data;
  end

  // control: enable plus two static levels
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctl) begin
      ctrl_q.en   <= wr_data[CTRL_EN_BIT];
      ctrl_q.dlvl <= wr_data[CTRL_DLVL_BIT];
      ctrl_q.slvl <= wr_data[CTRL_SLVL_BIT];
    end
  end

  // last winner record; bus reset takes precedence
  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      win_id_q  <= '1;
      win_pri_q <= '1;
    end else if (winner_valid) begin
      win_id_q  <= winner_id;
      win_pri_q <= winner_pri;
    end
  end

  always_comb begin
    unique case (addr)
      A_SCR:   rd_mux = scratch_q;
      A_CTL:   rd_mux = DATA_W'(ctrl_q);
      A_WID:   rd_mux = DATA_W'(win_id_q);
      A_PIN:   rd_mux = DATA_W'(pins_cap);
      A_WPR:   rd_mux = DATA_W'(win_pri_q);
      A_TXS:   rd_mux = DATA_W'(tx_stat);
      default: rd_mux = '0;
    endcase
  end

  // registered read port: samples pre-write state
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

endmodule

// File: rtl/link_dbg_regs.sv
module link_dbg_regs
  import link_dbg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ID_W        = 6,
  parameter int unsigned PRI_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              winner_valid,
  input  logic [ID_W-1:0]   winner_id,
  input  logic [PRI_W-1:0]  winner_pri,
  input  logic              bus_reset,
  input  logic              test_pin,
  input  logic              rx_data_pin,
  input  logic              rx_strb_pin,
  input  logic [1:0]        clk_sel,
  input  logic              tx_data_in,
  input  logic              tx_strb_in,
  input  logic              data_oe_in,
  input  logic              strb_oe_in,
  output logic              tx_data_out,
  output logic              tx_strb_out,
  output logic              data_oe,
  output logic              strb_oe
);

  logic [PINS_W-1:0] pins_raw;
  logic [PINS_W-1:0] pins_cap;
  ctrl_t             ctrl_q;
  tx_pins_t          normal_in;
  tx_pins_t          tx_q;
  logic              force_on;
  logic [DATA_W-1:0] scratch_q;
  logic [ID_W-1:0]   win_id_q;
  logic [PRI_W-1:0]  win_pri_q;

  assign pins_raw = {clk_sel, rx_strb_pin, rx_data_pin};

  link_dbg_sync #(
    .WIDTH  (PINS_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pins_raw),
    .sync_out (pins_cap)
  );

  assign normal_in.data    = tx_data_in;
  assign normal_in.strb    = tx_strb_in;
  assign normal_in.data_oe = data_oe_in;
  assign normal_in.strb_oe = strb_oe_in;

  link_dbg_override u_ovr (
    .clk       (clk),
    .rst       (rst),
    .hw_test   (test_pin),
    .ctrl      (ctrl_q),
    .normal_in (normal_in),
    .pins_q    (tx_q),
    .force_on  (force_on)
  );

  link_dbg_regfile #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .PRI_W  (PRI_W)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .winner_valid (winner_valid),
    .winner_id    (winner_id),
    .winner_pri   (winner_pri),
    .bus_reset    (bus_reset),
    .pins_cap     (pins_cap),
    .tx_stat      (tx_q),
    .ctrl_q       (ctrl_q),
    .scratch_q    (scratch_q),
    .win_id_q     (win_id_q),
    .win_pri_q    (win_pri_q)
  );

  assign tx_data_out = tx_q.data;
  assign tx_strb_out = tx_q.strb;
  assign data_oe     = tx_q.data_oe;
  assign strb_oe     = tx_q.strb_oe;

endmodule

// File: rtl/link_dbg_chk.sv
module link_dbg_chk
  import link_dbg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned PRI_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              winner_valid,
  input logic [ID_W-1:0]   winner_id,
  input logic [PRI_W-1:0]  winner_pri,
  input logic              bus_reset,
  input logic              test_pin,
  input logic              tx_data_in,
  input logic              tx_strb_in,
  input logic              data_oe_in,
  input logic              strb_oe_in,
  input logic              tx_data_out,
  input logic              tx_strb_out,
  input logic              data_oe,
  input logic              strb_oe,
  input ctrl_t             ctrl_q,
  input logic [DATA_W-1:0] scratch_q,
  input logic [ID_W-1:0]   win_id_q,
  input logic [PRI_W-1:0]  win_pri_q
);

  assert_scratch_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr) == ADDR_W'(ADR_SCRATCH))
      |-> scratch_q == $past(wr_data));

  assert_winner_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(winner_valid) && !$past(bus_reset))
      |-> (win_id_q == $past(winner_id) && win_pri_q == $past(winner_pri)));

  assert_bus_reset_ones_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_reset)) |-> (&win_id_q && &win_pri_q));

  assert_force_levels_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(test_pin) && $past(ctrl_q.en))
      |-> (tx_data_out == $past(ctrl_q.dlvl) && tx_strb_out == $past(ctrl_q.slvl)
           && data_oe && strb_oe));

  assert_pass_through_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(test_pin) && $past(ctrl_q.en)))
      |-> (tx_data_out == $past(tx_data_in) && tx_strb_out == $past(tx_strb_in)
           && data_oe == $past(data_oe_in) && strb_oe == $past(strb_oe_in)));

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && !is_mapped(int'($past(addr))))
      |-> rd_data == '0);

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));

endmodule

bind link_dbg_regs link_dbg_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ID_W   (ID_W),
  .PRI_W  (PRI_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .winner_valid (winner_valid),
  .winner_id    (winner_id),
  .winner_pri   (winner_pri),
  .bus_reset    (bus_reset),
  .test_pin     (test_pin),
  .tx_data_in   (tx_data_in),
  .tx_strb_in   (tx_strb_in),
  .data_oe_in   (data_oe_in),
  .strb_oe_in   (strb_oe_in),
  .tx_data_out  (tx_data_out),
  .tx_strb_out  (tx_strb_out),
  .data_oe      (data_oe),
  .strb_oe      (strb_oe),
  .ctrl_q       (ctrl_q),
  .scratch_q    (scratch_q),
  .win_id_q     (win_id_q),
  .win_pri_q    (win_pri_q)
);

// File: tb/test_link_dbg_regs.sv
module test_link_dbg_regs;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       winner_valid;
  logic [5:0] winner_id;
  logic [3:0] winner_pri;
  logic       bus_reset;
  logic       test_pin;
  logic       rx_data_drv, rx_strb_drv, loop_en;
  logic       rx_data_pin, rx_strb_pin;
  logic [1:0] clk_sel;
  logic       tx_data_in, tx_strb_in, data_oe_in, strb_oe_in;
  logic       tx_data_out, tx_strb_out, data_oe, strb_oe;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  assign rx_data_pin = loop_en ? tx_data_out : rx_data_drv;
  assign rx_strb_pin = loop_en ? tx_strb_out : rx_strb_drv;

  link_dbg_regs i_link_dbg_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .winner_valid(winner_valid),
    .winner_id(winner_id), .winner_pri(winner_pri), .bus_reset(bus_reset),
    .test_pin(test_pin), .rx_data_pin(rx_data_pin), .rx_strb_pin(rx_strb_pin),
    .clk_sel(clk_sel), .tx_data_in(tx_data_in), .tx_strb_in(tx_strb_in),
    .data_oe_in(data_oe_in), .strb_oe_in(strb_oe_in), .tx_data_out(tx_data_out),
    .tx_strb_out(tx_strb_out), .data_oe(data_oe), .strb_oe(strb_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_bits();
    return {4'b0, strb_oe, data_oe, tx_strb_out, tx_data_out};
  endfunction

  // all tasks start and end at a falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  // bench model state
  logic [7:0] m_scr;
  logic [2:0] m_ctl;
  logic [5:0] m_id;
  logic [3:0] m_pri;
  logic [3:0] m_tx;   // {strb_oe, data_oe, strb, data}

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'd0:    return m_scr;
      4'd1:    return {5'b0, m_ctl};
      4'd2:    return {2'b0, m_id};
      4'd6:    return {4'b0, m_pri};
      4'd7:    return {4'b0, m_tx};
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    logic [7:0] v;
    logic [7:0] exp_rd;
    logic       chk_rd;
    logic [3:0] alist [10];
    alist = '{4'd0, 4'd1, 4'd2, 4'd6, 4'd7, 4'd4, 4'd5, 4'd8, 4'd12, 4'd15};
    void'($urandom(32'h1394_5a5a));

    rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
    winner_valid = 0; winner_id = 0; winner_pri = 0; bus_reset = 0;
    test_pin = 0; rx_data_drv = 0; rx_strb_drv = 0; loop_en = 0; clk_sel = 0;
    tx_data_in = 0; tx_strb_in = 0; data_oe_in = 0; strb_oe_in = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 tx outputs", tx_bits(), 8'h00);
    do_read(4'd0, v); check("R1 scratch", v, 8'h00);
    do_read(4'd1, v); check("R1 control", v, 8'h00);
    do_read(4'd2, v); check("R1 winner id", v, 8'h3F);
    do_read(4'd6, v); check("R1 winner pri", v, 8'h0F);

    // R2 scratch patterns, including bits 7:6
    foreach (alist[k]) begin end
    do_write(4'd0, 8'hFF); do_read(4'd0, v); check("R2 ones", v, 8'hFF);
    do_write(4'd0, 8'hA5); do_read(4'd0, v); check("R2 a5", v, 8'hA5);
    do_write(4'd0, 8'h5A); do_read(4'd0, v); check("R2 5a", v, 8'h5A);
    do_write(4'd0, 8'hC0); do_read(4'd0, v); check("R2 top bits", v, 8'hC0);

    // R3 control readback, upper bits read 0
    do_write(4'd1, 8'hFE); do_read(4'd1, v); check("R3 control", v, 8'h06);
    do_write(4'd1, 8'h00); do_read(4'd1, v); check("R3 control clear", v, 8'h00);

    // R11 read in the same cycle as a write returns the old value
    wr_en = 1; rd_en = 1; addr = 4'd0; wr_data = 8'h33;
    tick();
    wr_en = 0; rd_en = 0;
    check("R11 read-before-write", rd_data, 8'hC0);
    tick();
    check("R11 hold without rd_en", rd_data, 8'hC0);

    // R5 bus reset and winner in the same cycle
    winner_valid = 1; winner_id = 6'h15; winner_pri = 4'h3; tick(); winner_valid = 0;
    do_read(4'd2, v); check("R4 winner id", v, 8'h15);
    do_read(4'd6, v); check("R4 winner pri", v, 8'h03);
    winner_valid = 1; bus_reset = 1; winner_id = 6'h02; winner_pri = 4'h1;
    tick();
    winner_valid = 0; bus_reset = 0;
    do_read(4'd2, v); check("R5 id after collision", v, 8'h3F);
    do_read(4'd6, v); check("R5 pri after collision", v, 8'h0F);

    // R10 writes to status addresses and unused addresses are ignored
    do_write(4'd2, 8'h00); do_write(4'd6, 8'h00); do_write(4'd3, 8'hFF);
    do_write(4'd7, 8'hFF); do_write(4'd9, 8'hFF);
    do_read(4'd2, v); check("R10 id unchanged", v, 8'h3F);
    do_read(4'd6, v); check("R10 pri unchanged", v, 8'h0F);
    do_read(4'd7, v); check("R10 tx stat unchanged", v, 8'h00);
    do_read(4'd9, v); check("R10 unused reads zero", v, 8'h00);
    do_read(4'd0, v); check("R10 scratch untouched", v, 8'h33);

    // R6 pin capture through the synchronizer
    rx_data_drv = 1; rx_strb_drv = 0; clk_sel = 2'b10;
    tick(); tick();
    do_read(4'd3, v); check("R6 capture a", v, 8'h09);
    rx_data_drv = 0; rx_strb_drv = 1; clk_sel = 2'b01;
    tick(); tick();
    do_read(4'd3, v); check("R6 capture b", v, 8'h06);

    // R7 DC override with loopback, R9 transmit status
    tx_data_in = 0; tx_strb_in = 1; data_oe_in = 0; strb_oe_in = 0;
    test_pin = 1; loop_en = 1; clk_sel = 2'b00;
    do_write(4'd1, 8'h03);           // en, data level 1, strobe level 0
    tick();
    check("R7 forced data=1 strb=0 oe on", tx_bits(), 8'h0D);
    tick(); tick();
    do_read(4'd3, v); check("R7 loopback data=1 strb=0", v, 8'h01);
    do_read(4'd7, v); check("R9 tx stat forced", v, 8'h0D);
    do_write(4'd1, 8'h05);           // en, data level 0, strobe level 1
    tick();
    check("R7 forced data=0 strb=1 oe on", tx_bits(), 8'h0E);
    tick(); tick();
    do_read(4'd3, v); check("R7 loopback data=0 strb=1", v, 8'h02);
    loop_en = 0;

    // R8 either condition low returns to pass-through
    test_pin = 0; tick();
    check("R8 test pin low", tx_bits(), 8'h02);
    test_pin = 1; do_write(4'd1, 8'h06); tick();
    check("R8 enable bit low", tx_bits(), 8'h02);
    do_read(4'd7, v); check("R9 tx stat normal", v, 8'h02);

    // model sync with directed state
    m_scr = 8'h33; m_ctl = 3'b110; m_id = 6'h3F; m_pri = 4'hF; m_tx = 4'b0010;

    // random phase: everything can coincide (R2 R3 R4 R5 R8 R9 R10 R11)
    for (int i = 0; i < 3000; i++) begin
      logic       force_now;
      logic [3:0] tx_next;
      wr_en        = ($urandom % 3) == 0;
      rd_en        = ($urandom % 2) == 0;
      addr         = ($urandom % 5 == 0) ? 4'($urandom) : alist[$urandom % 10];
      if (addr == 4'd3) addr = 4'd0;
      wr_data      = 8'($urandom);
      winner_valid = ($urandom % 4) == 0;
      winner_id    = 6'($urandom);
      winner_pri   = 4'($urandom);
      bus_reset    = ($urandom % 16) == 0;
      test_pin     = ($urandom % 2) == 0;
      tx_data_in   = 1'($urandom);
      tx_strb_in   = 1'($urandom);
      data_oe_in   = 1'($urandom);
      strb_oe_in   = 1'($urandom);

      chk_rd = rd_en;
      exp_rd = model_read(addr);
      force_now = test_pin && m_ctl[0];
      tx_next = force_now ? {2'b11, m_ctl[2], m_ctl[1]}
                          : {strb_oe_in, data_oe_in, tx_strb_in, tx_data_in};
      if (wr_en && addr == 4'd0) m_scr = wr_data;
      if (wr_en && addr == 4'd1) m_ctl = wr_data[2:0];
      if (bus_reset) begin m_id = 6'h3F; m_pri = 4'hF; end
      else if (winner_valid) begin m_id = winner_id; m_pri = winner_pri; end
      m_tx = tx_next;
      if (!chk_rd) exp_rd = rd_data;

      tick();
      check(force_now ? "R7 random forced outputs" : "R8 random pass-through",
            tx_bits(), {4'b0, m_tx});
      if (chk_rd) check("R11 random read (R9 R10 R4 R5)", rd_data, exp_rd);
      else        check("R11 random hold", rd_data, exp_rd);
    end
    wr_en = 0; rd_en = 0; winner_valid = 0; bus_reset = 0;

    tick();
    finish_run();
  end

endmodule